// File: doc/BRIEF.md
# Scatter-Gather Stream-to-Memory Write Engine

This block drains a stream of 256-bit words coming from user logic and turns it into memory write requests aimed at host or accelerator buffers. The destination buffers are listed in a small descriptor table. Each entry holds a physical byte address and a byte count of up to 2 GB. The host fills the table over a simple register write port. The engine walks the entries in order and cuts each buffer into bursts. A burst never exceeds a configurable payload and never crosses a 4 KB page. Once all data has left, the engine sends one extra write to a host-chosen address. That write tells the host how many bytes arrived.

The host starts a transfer with a command bit. The engine then moves the data and raises its done flag once the notification has been accepted. It stays busy until the host confirms receipt with a stop command. A cycle counter runs from the start command to the stop command. The host reads it back as the round-trip time, one count per clock (4 ns at 250 MHz). Output requests carry the address, the burst length, first and last markers, a notification flag and the data on every beat. Packet formatting is left to the downstream endpoint.

Top module: `sgdma_wr_engine`

## Requirements
- R1: After reset no request is valid, `in_ready` is low, and the status register (offset 0x03) reads zero.
- R2: A transfer begins only on a write to offset 0x00 with bit 0 set (start) while idle. Before that, no input word is taken. A start issued while busy is ignored. At a start, done clears and busy (status bit 0) sets.
- R3: Every data burst is at most MAX_PAYLOAD bytes (256 by default) and stays within one 4 KB page. `req_sop` marks the first beat of each burst and `req_eop` marks its last. Every beat of a burst carries that burst's start address and byte length. Entry addresses and lengths are multiples of 32 bytes.
- R4: Entries are used from index 0 up to the programmed last index (offset 0x01), and entries of length zero are skipped. After the final entry the current index (status bits [8+:3]) returns to 0.
- R5: Input words appear on the output in arrival order, one per beat. An empty input pauses a burst without ending it. While `req_ready` is low, the request and its data hold steady.
- R6: After the last data beat, exactly one request goes out with `req_notify` high. Its address is the notification address written at offset 0x02, and its data is the total number of bytes moved.
- R7: Done (status bit 1) sets once the notification is accepted. Busy stays set until a write to offset 0x00 with bit 1 set (stop), which returns the engine to idle. Done then holds until the next start.
- R8: While busy, writes to the descriptor table, the last index and the notification address have no effect. Table writes use an address with bit 7 set. Bits [3:1] select the entry, and bit 0 selects the byte address (0) or the byte length (1).
- R9: The latency register (offset 0x04) holds the number of clock edges from the start command to the stop command, counting the stop edge.
- R10: Register reads return the value of the addressed register on `reg_rd_data` one clock after `reg_rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write offset |
| reg_wr_data | input | 64 | Register write value |
| reg_rd_addr | input | 8 | Register read offset |
| reg_rd_data | output | 64 | Registered read value |
| in_valid | input | 1 | Input word available |
| in_data | input | 256 | Input word |
| in_ready | output | 1 | Input word taken this cycle |
| req_valid | output | 1 | Write request beat valid |
| req_ready | input | 1 | Downstream accepts beat |
| req_addr | output | 64 | Burst start byte address |
| req_bytes | output | 32 | Burst length in bytes |
| req_sop | output | 1 | First beat of a burst |
| req_eop | output | 1 | Last beat of a burst |
| req_notify | output | 1 | Beat is the completion notice |
| req_data | output | 256 | Beat payload |

## Verification
Input starvation and output backpressure can hit the engine in the same cycle, in the middle of a burst. The first stops words entering and the second freezes the beat already staged. The bench drives `in_valid` and `req_ready` from independent random draws, so both pauses land together, on their own, and at burst and page edges. Each accepted beat is compared against a stream the bench computes from the descriptors: address, length, markers and payload order. A lost, repeated or reordered word, or a burst cut in the wrong place, shows up as a mismatch on that beat.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FETCH,
    ST_PLAN,
    ST_DATA,
    ST_NOTE,
    ST_HOLD
  } sg_state_t;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 1;
  localparam int STAT_IDX_LSB  = 8;
  localparam int NOTE_BYTES    = 8;
endpackage

// File: rtl/sgdma_desc_table.sv
module sgdma_desc_table #(
  parameter int N  = 8,
  parameter int AW = 64,
  parameter int LW = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wsel,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [AW-1:0] raddr_q,
  output logic [LW-1:0] rlen_q
);
  logic [AW-1:0] addr_mem [N];
  logic [LW-1:0] len_mem  [N];

  always_ff @(posedge clk) begin
    if (we && !wsel) addr_mem[widx] <= wdata;
    if (we && wsel)  len_mem[widx]  <= wdata[LW-1:0];
    raddr_q <= addr_mem[ridx];
    rlen_q  <= len_mem[ridx];
  end
endmodule

// File: rtl/sgdma_burst_calc.sv
module sgdma_burst_calc #(
  parameter int LW          = 32,
  parameter int MAX_PAYLOAD = 256,
  parameter int PAGE_BYTES  = 4096,
  localparam int PG_LG      = $clog2(PAGE_BYTES)
) (
  input  logic [PG_LG-1:0] page_off,
  input  logic [LW-1:0]    rem,
  output logic [LW-1:0]    bytes
);
  localparam logic [LW-1:0] MAXP = LW'(MAX_PAYLOAD);
  localparam logic [LW-1:0] PAGE = LW'(PAGE_BYTES);

  logic [LW-1:0] to_page;

  always_comb begin
    to_page = PAGE - LW'(page_off);
    bytes = rem;
    if (bytes > MAXP)    bytes = MAXP;
    if (bytes > to_page) bytes = to_page;
  end
endmodule

// File: rtl/sgdma_latency.sv
module sgdma_latency #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         run,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (clear) count <= '0;
    else if (run)   count <= count + 1'b1;
  end

  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    (run && !clear) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/sgdma_wr_engine.sv
module sgdma_wr_engine
  import sgdma_pkg::*;
#(
  parameter int DATA_W      = 256,
  parameter int ADDR_W      = 64,
  parameter int LEN_W       = 32,
  parameter int N_DESC      = 8,
  parameter int MAX_PAYLOAD = 256,
  parameter int PAGE_BYTES  = 4096,
  parameter int REG_AW      = 8,
  parameter int REG_DW      = 64,
  parameter int LAT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [REG_DW-1:0] reg_wr_data,
  input  logic [REG_AW-1:0] reg_rd_addr,
  output logic [REG_DW-1:0] reg_rd_data,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_bytes,
  output logic              req_sop,
  output logic              req_eop,
  output logic              req_notify,
  output logic [DATA_W-1:0] req_data
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_LG    = $clog2(BEAT_BYTES);
  localparam int IDX_W      = (N_DESC > 1) ? $clog2(N_DESC) : 1;
  localparam int BEATS_W    = $clog2(MAX_PAYLOAD / BEAT_BYTES) + 1;
  localparam int PG_LG      = $clog2(PAGE_BYTES);
  localparam int TOT_W      = LEN_W + IDX_W;

  localparam logic [REG_AW-1:0] A_CTRL   = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_LAST   = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_NOTE   = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_STATUS = REG_AW'(3);
  localparam logic [REG_AW-1:0] A_LAT    = REG_AW'(4);

  sg_state_t state;

  logic [IDX_W-1:0]   idx, last_idx;
  logic [ADDR_W-1:0]  note_addr, cur_addr, burst_addr;
  logic [LEN_W-1:0]   cur_rem, burst_bytes, calc_bytes;
  logic [TOT_W-1:0]   total;
  logic [BEATS_W-1:0] beats_left;
  logic               first_beat, done;
  logic [ADDR_W-1:0]  tbl_addr_q;
  logic [LEN_W-1:0]   tbl_len_q;
  logic [LAT_W-1:0]   lat;

  // Host command decode
  logic busy, is_table, tbl_we, cmd_start, cmd_stop, out_free, beat_fire;
  logic [IDX_W-1:0] wr_idx;

  assign busy      = (state != ST_IDLE);
  assign is_table  = reg_wr_addr[REG_AW-1];
  assign wr_idx    = reg_wr_addr[IDX_W:1];
  assign tbl_we    = reg_wr_en && is_table && !busy;
  assign cmd_start = reg_wr_en && (reg_wr_addr == A_CTRL) && reg_wr_data[0];
  assign cmd_stop  = reg_wr_en && (reg_wr_addr == A_CTRL) && reg_wr_data[1];

  // One output register stage; ready flows back to the input FIFO
  assign out_free  = !req_valid || req_ready;
  assign in_ready  = (state == ST_DATA) && out_free;
  assign beat_fire = in_valid && in_ready;

  sgdma_desc_table #(
    .N(N_DESC), .AW(ADDR_W), .LW(LEN_W), .IW(IDX_W)
  ) u_table (
    .clk     (clk),
    .we      (tbl_we),
    .wsel    (reg_wr_addr[0]),
    .widx    (wr_idx),
    .wdata   (reg_wr_data[ADDR_W-1:0]),
    .ridx    (idx),
    .raddr_q (tbl_addr_q),
    .rlen_q  (tbl_len_q)
  );

  sgdma_burst_calc #(
    .LW(LEN_W), .MAX_PAYLOAD(MAX_PAYLOAD), .PAGE_BYTES(PAGE_BYTES)
  ) u_calc (
    .page_off (cur_addr[PG_LG-1:0]),
    .rem      (cur_rem),
    .bytes    (calc_bytes)
  );

  sgdma_latency #(.W(LAT_W)) u_lat (
    .clk   (clk),
    .rst   (rst),
    .clear (cmd_start && !busy),
    .run   (busy),
    .count (lat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      idx         <= '0;
      last_idx    <= '0;
      note_addr   <= '0;
      cur_addr    <= '0;
      cur_rem     <= '0;
      burst_addr  <= '0;
      burst_bytes <= '0;
      total       <= '0;
      beats_left  <= '0;
      first_beat  <= 1'b0;
      done        <= 1'b0;
      req_valid   <= 1'b0;
      req_addr    <= '0;
      req_bytes   <= '0;
      req_sop     <= 1'b0;
      req_eop     <= 1'b0;
      req_notify  <= 1'b0;
      req_data    <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;

      if (reg_wr_en && !busy && reg_wr_addr == A_LAST) last_idx  <= reg_wr_data[IDX_W-1:0];
      if (reg_wr_en && !busy && reg_wr_addr == A_NOTE) note_addr <= reg_wr_data[ADDR_W-1:0];

      case (state)
        ST_IDLE: if (cmd_start) begin
          state <= ST_LOAD;
          idx   <= '0;
          total <= '0;
          done  <= 1'b0;
        end
        ST_LOAD: state <= ST_FETCH;
        ST_FETCH: begin
          cur_addr <= tbl_addr_q & ~ADDR_W'(BEAT_BYTES - 1);
          cur_rem  <= tbl_len_q & ~LEN_W'(BEAT_BYTES - 1);
          state    <= ST_PLAN;
        end
        ST_PLAN: begin
          if (cur_rem == '0) begin
            if (idx == last_idx) begin
              idx   <= '0;
              state <= ST_NOTE;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_LOAD;
            end
          end else begin
            burst_addr  <= cur_addr;
            burst_bytes <= calc_bytes;
            cur_addr    <= cur_addr + ADDR_W'(calc_bytes);
            cur_rem     <= cur_rem - calc_bytes;
            total       <= total + TOT_W'(calc_bytes);
            beats_left  <= BEATS_W'(calc_bytes >> BEAT_LG);
            first_beat  <= 1'b1;
            state       <= ST_DATA;
          end
        end
        ST_DATA: if (beat_fire) begin
          req_valid  <= 1'b1;
          req_data   <= in_data;
          req_addr   <= burst_addr;
          req_bytes  <= burst_bytes;
          req_sop    <= first_beat;
          req_eop    <= (beats_left == BEATS_W'(1));
          req_notify <= 1'b0;
          first_beat <= 1'b0;
          beats_left <= beats_left - 1'b1;
          if (beats_left == BEATS_W'(1)) state <= ST_PLAN;
        end
        ST_NOTE: if (out_free) begin
          req_valid  <= 1'b1;
          req_data   <= DATA_W'(total);
          req_addr   <= note_addr;
          req_bytes  <= LEN_W'(NOTE_BYTES);
          req_sop    <= 1'b1;
          req_eop    <= 1'b1;
          req_notify <= 1'b1;
          state      <= ST_HOLD;
        end
        ST_HOLD: if (req_valid && req_ready && req_notify) done <= 1'b1;
        default: state <= ST_IDLE;
      endcase

      if (cmd_stop && busy) state <= ST_IDLE;
    end
  end

  // Register read-back, one cycle latency
  logic [REG_DW-1:0] status_word;
  always_comb begin
    status_word = '0;
    status_word[STAT_BUSY_BIT] = busy;
    status_word[STAT_DONE_BIT] = done;
    status_word[STAT_IDX_LSB +: IDX_W] = idx;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rd_data <= '0;
    else begin
      case (reg_rd_addr)
        A_STATUS: reg_rd_data <= status_word;
        A_LAT:    reg_rd_data <= REG_DW'(lat);
        default:  reg_rd_data <= '0;
      endcase
    end
  end

  assert_hold_beat_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_data) &&
                                   $stable(req_addr) && $stable(req_notify)));

  assert_burst_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sop && !req_notify) |->
      (req_bytes != '0 && req_bytes <= LEN_W'(MAX_PAYLOAD) &&
       (LEN_W'(req_addr[PG_LG-1:0]) + req_bytes) <= LEN_W'(PAGE_BYTES)));

  assert_start_only_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_start));

  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx <= last_idx));

  assert_frozen_cfg_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(last_idx) && $stable(note_addr)));
endmodule

// File: tb/sgdma_wr_engine_test.sv
module sgdma_wr_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic         reg_wr_en = 1'b0;
  logic [7:0]   reg_wr_addr = '0;
  logic [63:0]  reg_wr_data = '0;
  logic [7:0]   reg_rd_addr = '0;
  logic [63:0]  reg_rd_data;
  logic         in_valid = 1'b0;
  logic [255:0] in_data = '0;
  logic         in_ready;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [63:0]  req_addr;
  logic [31:0]  req_bytes;
  logic         req_sop, req_eop, req_notify;
  logic [255:0] req_data;

  sgdma_wr_engine uut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_sop(req_sop), .req_eop(req_eop),
    .req_notify(req_notify), .req_data(req_data)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  logic [63:0] t_addr [8];
  int unsigned t_len [8];
  int unsigned last_i;
  logic [63:0] note;
  logic [63:0] exp_a [256];
  int unsigned exp_b [256];
  int unsigned nexp, exp_total;
  int unsigned c0, c1;
  logic [63:0] rv;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] pattern(input int unsigned k);
    return {8{k}};
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [63:0] d, output int unsigned c);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 8'h00; reg_wr_data = d;
    c = cyc;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_rd_addr = a;
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic prog_entry(input int i, input logic [63:0] a, input int unsigned l);
    reg_write(8'h80 + 8'(2 * i), a);
    reg_write(8'h81 + 8'(2 * i), 64'(l));
  endtask

  // Expected burst list from the descriptor shadow (R3, R4)
  task automatic build_expect();
    nexp = 0; exp_total = 0;
    for (int e = 0; e <= int'(last_i); e++) begin
      logic [63:0] a;
      int unsigned r, b, to;
      a = t_addr[e]; r = t_len[e];
      while (r > 0) begin
        to = 4096 - int'(a[11:0]);
        b = r;
        if (b > 256) b = 256;
        if (b > to) b = to;
        exp_a[nexp] = a; exp_b[nexp] = b;
        nexp++; a += 64'(b); r -= b; exp_total += b;
      end
    end
  endtask

  task automatic run_stream(input bit rin, input bit rout);
    int unsigned word, beat, bi, bb, words, guard;
    bit got_note;
    word = 0; beat = 0; bi = 0; bb = 0; guard = 0; got_note = 0;
    words = exp_total / 32;
    while (!got_note && guard < 20000) begin
      @(negedge clk);
      guard++;
      req_ready = rout ? ($urandom % 4 != 0) : 1'b1;
      in_valid  = (word < words) && (rin ? ($urandom % 3 != 0) : 1'b1);
      in_data   = pattern(word);
      #1;
      if (req_valid && req_ready) begin
        if (bi < nexp) begin
          int unsigned nb;
          nb = exp_b[bi] / 32;
          check(req_notify == 1'b0, "R6 early notify", 64'(req_notify), 64'd0);
          check(req_addr == exp_a[bi], "R3 burst address", req_addr, exp_a[bi]);
          check(req_bytes == exp_b[bi], "R3 burst bytes", 64'(req_bytes), 64'(exp_b[bi]));
          check(req_sop == (bb == 0) && req_eop == (bb == nb - 1), "R3 sop/eop",
                64'({req_sop, req_eop}), 64'({bb == 0, bb == nb - 1}));
          check(req_data == pattern(beat), "R5 data order", req_data[63:0], pattern(beat) >> 0);
          beat++; bb++;
          if (bb == nb) begin bb = 0; bi++; end
        end else begin
          check(req_notify == 1'b1, "R6 notify flag", 64'(req_notify), 64'd1);
          check(req_addr == note, "R6 notify address", req_addr, note);
          check(req_data == 256'(exp_total), "R6 notify total", req_data[63:0], 64'(exp_total));
          got_note = 1'b1;
        end
      end
      if (in_valid && in_ready) word++;
    end
    check(got_note, "R6 notify seen", 64'(got_note), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    req_ready = 1'b1;
  endtask

  initial begin
    #1_800_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0 && in_ready == 1'b0, "R1 outputs idle in reset",
          64'({req_valid, in_ready}), 64'd0);
    rst = 1'b0;
    reg_read(8'h03, rv);
    check(rv == 64'd0, "R1 status after reset", rv, 64'd0);

    // Input offered before any start must not be taken (R2)
    in_valid = 1'b1; in_data = pattern(99);
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0 && req_valid == 1'b0, "R2 no transfer before start",
          64'({in_ready, req_valid}), 64'd0);
    in_valid = 1'b0;

    // Directed: page crossing, empty entry, unaligned-to-payload start
    t_addr[0] = 64'h1000_0FC0; t_len[0] = 256;
    t_addr[1] = 64'h0000_8000; t_len[1] = 0;
    t_addr[2] = 64'h0000_2020; t_len[2] = 608;
    last_i = 2; note = 64'h0000_ABC0;
    for (int i = 0; i < 3; i++) prog_entry(i, t_addr[i], t_len[i]);
    reg_write(8'h01, 64'(last_i));
    reg_write(8'h02, note);
    build_expect();
    cmd(64'd1, c0);
    reg_read(8'h03, rv);
    check(rv[1:0] == 2'b01, "R2 busy set done clear at start", 64'(rv[1:0]), 64'd1);
    run_stream(1'b1, 1'b1);
    repeat (3) @(negedge clk);
    reg_read(8'h03, rv);
    check(rv == 64'h3, "R7 done and busy, R4 index back to 0", rv, 64'h3);

    // Writes while busy are ignored (R8), so is a second start (R2)
    prog_entry(0, 64'h0000_5000, 32);
    reg_write(8'h01, 64'd0);
    reg_write(8'h02, 64'h0000_7700);
    reg_write(8'h00, 64'd1);
    reg_read(8'h03, rv);
    check(rv == 64'h3, "R2 start while busy ignored", rv, 64'h3);
    cmd(64'd2, c1);
    reg_read(8'h03, rv);
    check(rv == 64'h2, "R7 stop returns idle, done held", rv, 64'h2);
    reg_read(8'h04, rv);
    check(rv == 64'(c1 - c0), "R9 latency start to stop", rv, 64'(c1 - c0));
    reg_read(8'h05, rv);
    check(rv == 64'd0, "R10 unmapped offset reads zero", rv, 64'd0);

    // Same table, streaming without gaps: old descriptors still apply (R8)
    cmd(64'd1, c0);
    run_stream(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    cmd(64'd2, c1);
    reg_read(8'h04, rv);
    check(rv == 64'(c1 - c0), "R9 latency second run", rv, 64'(c1 - c0));

    // Random descriptors over all eight entries
    for (int i = 0; i < 8; i++) begin
      t_addr[i] = 64'($urandom % 65536) << 5;
      t_len[i]  = ($urandom % 33) * 32;
      if (i == 3) t_len[i] = 0;
      prog_entry(i, t_addr[i], t_len[i]);
    end
    last_i = 7; note = 64'h0001_0040;
    reg_write(8'h01, 64'(last_i));
    reg_write(8'h02, note);
    build_expect();
    cmd(64'd1, c0);
    run_stream(1'b1, 1'b1);
    repeat (2) @(negedge clk);
    reg_read(8'h03, rv);
    check(rv == 64'h3, "R4 wrap to entry 0 after last", rv, 64'h3);
    cmd(64'd2, c1);
    reg_read(8'h04, rv);
    check(rv == 64'(c1 - c0), "R9 latency random run", rv, 64'(c1 - c0));
    reg_read(8'h03, rv);
    check(rv == 64'h2, "R7 idle after final stop", rv, 64'h2);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule